// File: doc/BRIEF.md
# Packing ADC Sample Capture Unit

This block sits in the ADC clock domain and takes a burst of converter readings each time it is asked to. A request strobe starts a capture of a programmed number of readings. Each reading is optionally re-coded from offset binary to two's complement, and a parameter sets how many readings are packed into one output word. Words leave on a stream master port that carries only a data bus and a valid flag. The block has no back-pressure input. When the last reading of a burst has been taken, a one-cycle completion strobe tells the requester that the burst is over.

Any reading that arrives with its overrange flag raised is dropped: it is neither stored nor counted. A burst therefore lasts as many clock cycles as it takes to collect the programmed number of good readings. If the programmed count is not a multiple of the packing factor, the final word goes out partly filled, and its unused slots are zero. The clock-domain crossing of the request and completion strobes is done outside this block.

Top module: `adc_pack_capture`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, `m_axis_tvalid` and `cap_done` are low.
- R2: In idle, a high `cap_req` at a clock edge starts a capture of `sample_count` readings, with the count latched at that edge. Readings are taken from the next edge on, and no beat is produced while idle.
- R3: At an edge where `sample_ovr` is high during a capture, the reading is not stored or counted, and no beat results from it.
- R4: With FORMAT_SEL = 0, each stored slot equals the input reading unchanged.
- R5: With FORMAT_SEL = 1, each stored slot equals the input reading with its most significant bit inverted (offset binary to two's complement).
- R6: Reading k of a word (k counted from 0) occupies bits [SAMPLE_W*k +: SAMPLE_W]. When the reading that fills slot PACK_N-1 is taken, `m_axis_tvalid` is high for exactly the following cycle with that word.
- R7: If the burst ends with a word not full, that word is emitted in the cycle after the last reading, and its unused slots are zero.
- R8: `cap_done` is high for exactly one cycle: the cycle after the last reading of the burst is taken, which is the same cycle as the final beat.
- R9: A `cap_req` raised while a capture is running is ignored. The running burst keeps its count, and no further beats follow its completion.
- R10: A request with `sample_count` = 0 raises `cap_done` in the next cycle and produces no beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ADC-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_req | input | 1 | Capture request, sampled while idle |
| sample_in | input | SAMPLE_W | Converter reading |
| sample_ovr | input | 1 | Overrange flag for the reading on `sample_in` |
| sample_count | input | CNT_W | Readings to take per request |
| m_axis_tdata | output | SAMPLE_W*PACK_N | Packed output word |
| m_axis_tvalid | output | 1 | Word valid, one cycle per beat |
| cap_done | output | 1 | Burst-complete pulse |

## Verification
The bench builds two copies that are driven in lockstep. The first uses 12-bit readings, a packing factor of 3 and two's-complement output. It is used to check slot placement, partial final words, MSB inversion and the way dropped readings move word boundaries. The second uses a packing factor of 1 and raw format, so every single reading shows up unchanged on the bus. Together the two copies show that beat timing and the done pulse do not depend on the packing factor.

// File: rtl/adc_pack_pkg.sv
package adc_pack_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } cap_state_e;

    typedef enum int unsigned {
        FMT_RAW  = 0,
        FMT_TWOS = 1
    } fmt_sel_e;

    typedef struct packed {
        logic take;
        logic last;
    } take_info_t;

endpackage

// File: rtl/sample_fmt.sv
module sample_fmt #(
    parameter int unsigned SAMPLE_W   = 12,
    parameter int unsigned FORMAT_SEL = 0
) (
    input  logic [SAMPLE_W-1:0] raw_i,
    output logic [SAMPLE_W-1:0] conv_o
);
    import adc_pack_pkg::*;

    generate
        if (FORMAT_SEL == FMT_TWOS) begin : g_twos
            assign conv_o = {~raw_i[SAMPLE_W-1], raw_i[SAMPLE_W-2:0]};
        end else begin : g_raw
            assign conv_o = raw_i;
        end
    endgenerate

endmodule

// File: rtl/capture_ctrl.sv
module capture_ctrl #(
    parameter int unsigned CNT_W = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_i,
    input  logic                     ovr_i,
    input  logic [CNT_W-1:0]         count_i,
    output adc_pack_pkg::take_info_t tk_o,
    output logic                     busy_o,
    output logic                     done_o
);
    import adc_pack_pkg::*;

    cap_state_e       state_q;
    logic [CNT_W-1:0] taken_q;
    logic [CNT_W-1:0] target_q;

    always_comb begin
        tk_o.take = (state_q == ST_RUN) && !ovr_i;
        tk_o.last = tk_o.take && (taken_q == target_q - CNT_W'(1));
    end

    assign busy_o = (state_q == ST_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            taken_q  <= '0;
            target_q <= '0;
            done_o   <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req_i) begin
                        target_q <= count_i;
                        taken_q  <= '0;
                        if (count_i == '0) begin
                            done_o <= 1'b1;
                        end else begin
                            state_q <= ST_RUN;
                        end
                    end
                end
                default: begin
                    if (tk_o.take) begin
                        taken_q <= taken_q + CNT_W'(1);
                        if (tk_o.last) begin
                            state_q <= ST_IDLE;
                            done_o  <= 1'b1;
                        end
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/word_packer.sv
module word_packer #(
    parameter int unsigned SAMPLE_W = 12,
    parameter int unsigned PACK_N   = 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  adc_pack_pkg::take_info_t     tk_i,
    input  logic [SAMPLE_W-1:0]          slot_i,
    output logic [SAMPLE_W*PACK_N-1:0]   tdata_o,
    output logic                         tvalid_o
);
    localparam int unsigned WORD_W = SAMPLE_W * PACK_N;
    localparam int unsigned IDX_W  = (PACK_N > 1) ? $clog2(PACK_N) : 1;

    logic [WORD_W-1:0] acc_q;
    logic [WORD_W-1:0] merged;
    logic [IDX_W-1:0]  idx_q;
    logic              full;

    genvar g;
    generate
        for (g = 0; g < PACK_N; g++) begin : g_slot
            assign merged[g*SAMPLE_W +: SAMPLE_W] =
                (tk_i.take && (idx_q == IDX_W'(g))) ? slot_i
                                                    : acc_q[g*SAMPLE_W +: SAMPLE_W];
        end
    endgenerate

    assign full = (idx_q == IDX_W'(PACK_N - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q    <= '0;
            idx_q    <= '0;
            tdata_o  <= '0;
            tvalid_o <= 1'b0;
        end else begin
            tvalid_o <= 1'b0;
            if (tk_i.take) begin
                if (full || tk_i.last) begin
                    tdata_o  <= merged;
                    tvalid_o <= 1'b1;
                    acc_q    <= '0;
                    idx_q    <= '0;
                end else begin
                    acc_q <= merged;
                    idx_q <= idx_q + IDX_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/adc_pack_capture.sv
module adc_pack_capture #(
    parameter int unsigned SAMPLE_W   = 12,
    parameter int unsigned PACK_N     = 1,
    parameter int unsigned FORMAT_SEL = 0,
    parameter int unsigned CNT_W      = 32
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cap_req,
    input  logic [SAMPLE_W-1:0]           sample_in,
    input  logic                          sample_ovr,
    input  logic [CNT_W-1:0]              sample_count,
    output logic [SAMPLE_W*PACK_N-1:0]    m_axis_tdata,
    output logic                          m_axis_tvalid,
    output logic                          cap_done
);
    import adc_pack_pkg::*;

    take_info_t          tk;
    logic                busy;
    logic                take;
    logic                take_last;
    logic [SAMPLE_W-1:0] conv;

    assign take      = tk.take;
    assign take_last = tk.last;

    sample_fmt #(
        .SAMPLE_W  (SAMPLE_W),
        .FORMAT_SEL(FORMAT_SEL)
    ) fmt_i (
        .raw_i (sample_in),
        .conv_o(conv)
    );

    capture_ctrl #(
        .CNT_W(CNT_W)
    ) ctrl_i (
        .clk    (clk),
        .rst    (rst),
        .req_i  (cap_req),
        .ovr_i  (sample_ovr),
        .count_i(sample_count),
        .tk_o   (tk),
        .busy_o (busy),
        .done_o (cap_done)
    );

    word_packer #(
        .SAMPLE_W(SAMPLE_W),
        .PACK_N  (PACK_N)
    ) pack_i (
        .clk     (clk),
        .rst     (rst),
        .tk_i    (tk),
        .slot_i  (conv),
        .tdata_o (m_axis_tdata),
        .tvalid_o(m_axis_tvalid)
    );

endmodule

// File: rtl/adc_pack_capture_chk.sv
module adc_pack_capture_chk (
    input logic clk,
    input logic rst,
    input logic cap_req,
    input logic sample_ovr,
    input logic busy,
    input logic take,
    input logic take_last,
    input logic m_axis_tvalid,
    input logic cap_done
);

    AST_RESET_QUIET: assert property (@(posedge clk)
        $fell(rst) |-> (!m_axis_tvalid && !cap_done)); // R1

    AST_IDLE_NO_BEAT: assert property (@(posedge clk) disable iff (rst)
        !busy |=> !m_axis_tvalid); // R2

    AST_OVR_NO_BEAT: assert property (@(posedge clk) disable iff (rst)
        (busy && sample_ovr) |=> !m_axis_tvalid); // R3

    AST_LAST_BEAT: assert property (@(posedge clk) disable iff (rst)
        take_last |=> m_axis_tvalid); // R7

    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        take_last |=> cap_done); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        cap_done |=> !cap_done); // R8

    AST_REQ_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy && cap_req && !take_last) |=> busy); // R9

    AST_TAKE_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        take |-> busy); // R2

endmodule

bind adc_pack_capture adc_pack_capture_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .cap_req      (cap_req),
    .sample_ovr   (sample_ovr),
    .busy         (busy),
    .take         (take),
    .take_last    (take_last),
    .m_axis_tvalid(m_axis_tvalid),
    .cap_done     (cap_done)
);

// File: tb/adc_pack_capture_tb_top.sv
`timescale 1ns/1ps
module adc_pack_capture_tb_top;

    localparam int W  = 12;
    localparam int PK = 3;

    logic clk = 1'b0;
    logic rst;
    logic req;
    logic [W-1:0] smp;
    logic ovr;
    logic [31:0] cnt;

    logic [W*PK-1:0] tdata_p;
    logic            tvalid_p;
    logic            done_p;
    logic [W-1:0]    tdata_r;
    logic            tvalid_r;
    logic            done_r;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #10 clk = ~clk;

    adc_pack_capture #(.SAMPLE_W(W), .PACK_N(PK), .FORMAT_SEL(1), .CNT_W(32)) dut_i (
        .clk(clk), .rst(rst), .cap_req(req), .sample_in(smp), .sample_ovr(ovr),
        .sample_count(cnt), .m_axis_tdata(tdata_p), .m_axis_tvalid(tvalid_p),
        .cap_done(done_p));

    adc_pack_capture #(.SAMPLE_W(W), .PACK_N(1), .FORMAT_SEL(0), .CNT_W(32)) dut_raw (
        .clk(clk), .rst(rst), .cap_req(req), .sample_in(smp), .sample_ovr(ovr),
        .sample_count(cnt), .m_axis_tdata(tdata_r), .m_axis_tvalid(tvalid_r),
        .cap_done(done_r));

    task automatic chk(input bit ok, input string req_tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req_tag, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        cycles++;
    endtask

    function automatic logic [W-1:0] val(input int i);
        return W'(i * 613 + 100);
    endfunction

    task automatic idle_quiet(input int ncyc, input string tag);
        req = 1'b0; ovr = 1'b0;
        for (int c = 0; c < ncyc; c++) begin
            step();
            chk(!tvalid_p && !tvalid_r, tag, "no beat when idle", {tvalid_p, tvalid_r}, 0);
            chk(!done_p && !done_r, tag, "no done when idle", {done_p, done_r}, 0);
        end
    endtask

    // Runs one burst of n readings; ovr_bits marks dropped cycles; req_again re-raises request mid-burst
    task automatic run_burst(input int n, input logic [31:0] ovr_bits, input int req_again,
                             input string tag);
        int taken = 0;
        int slot = 0;
        int i = 0;
        logic [W*PK-1:0] word = '0;
        cnt = n; req = 1'b1; ovr = 1'b0;
        step();
        req = 1'b0;
        cnt = 32'd2;
        if (n == 0) begin
            chk(done_p && done_r, "R10", "done for zero count", {done_p, done_r}, 3);
            chk(!tvalid_p && !tvalid_r, "R10", "no beat for zero count", {tvalid_p, tvalid_r}, 0);
        end
        while (taken < n) begin
            bit drop;
            bit last;
            bit ev3;
            logic [W-1:0] s;
            s = val(i);
            drop = ovr_bits[i % 32];
            smp = s; ovr = drop; req = (i == req_again);
            step();
            if (!drop) begin
                word[slot*W +: W] = {~s[W-1], s[W-2:0]};
                slot++;
                taken++;
            end
            last = (taken == n) && !drop;
            ev3 = !drop && ((slot == PK) || last);
            chk(tvalid_p == ev3, drop ? "R3" : "R6", "packed tvalid", tvalid_p, ev3);
            if (ev3) begin
                chk(tdata_p == word, last && slot < PK ? "R7" : "R5", "packed word",
                    tdata_p, word);
                word = '0; slot = 0;
            end
            chk(tvalid_r == !drop, drop ? "R3" : "R2", "raw tvalid", tvalid_r, !drop);
            if (!drop) chk(tdata_r == s, "R4", "raw data", tdata_r, s);
            chk(done_p == last && done_r == last, "R8", "done timing",
                {done_p, done_r}, {last, last});
            i++;
        end
        idle_quiet(3, tag);
    endtask

    task automatic t_reset();
        rst = 1'b1; req = 1'b0; ovr = 1'b0; smp = '0; cnt = '0;
        step(); step();
        chk(!tvalid_p && !tvalid_r && !done_p && !done_r, "R1", "outputs in reset",
            {tvalid_p, tvalid_r, done_p, done_r}, 0);
        rst = 1'b0;
        step();
        chk(!tvalid_p && !tvalid_r && !done_p && !done_r, "R1", "outputs after reset",
            {tvalid_p, tvalid_r, done_p, done_r}, 0);
    endtask

    task automatic t_full_words();   run_burst(6, 32'h0, -1, "R6"); endtask
    task automatic t_partial();      run_burst(5, 32'h0, -1, "R7"); endtask
    task automatic t_ovr();          run_burst(7, 32'b0010_0110, -1, "R3"); endtask
    task automatic t_req_ignored();  run_burst(4, 32'h0, 1, "R9"); endtask
    task automatic t_zero();         run_burst(0, 32'h0, -1, "R10"); endtask
    task automatic t_idle();         idle_quiet(4, "R2"); endtask

    initial begin
        t_reset();
        t_idle();
        t_full_words();
        t_partial();
        t_ovr();
        t_req_ignored();
        t_zero();
        t_full_words();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #200000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule